// File: doc/BRIEF.md
# Execution Mode Switch Controller

This controller chooses whether a core runs its threads out of order or in order with many hardware threads, and it sequences the change from one mode to the other. While idle it compares the number of active threads with a limit. When the mode that count calls for differs from the current one, it starts a switch. The switch steps through four phases in a fixed order: drain, spill, reconfigure and fill.

Each phase with external work raises a request and holds it until the matching done input arrives. The drain phase empties the pipeline. The spill phase saves the architectural registers of the running threads to reserved cache ways. The fill phase loads the registers of the threads that will run next. In the reconfigure phase the controller itself turns register renaming, out-of-order scheduling and the load queue on or off, and that phase lasts a fixed number of cycles.

Fetch is held stalled for the whole switch. A mode-valid flag is raised once the switch is over. A counter records how many cycles the most recent switch took, and the current phase is visible as a 3-bit code. The request/done pairs are level handshakes. Each request stays high until its done input is seen, so the external engines can take as long as they need.

Top module: `exec_mode_ctrl`

## Requirements
- R1: After reset the phase code is 0 (idle) and the core is in out-of-order mode with `rename_en`, `ooo_sched_en` and `ldq_en` all 1. `mode_valid` is 1. `fetch_stall`, all requests and `switch_cycles` are 0.
- R2: In idle, a thread count of at most `OOO_MAX` selects out-of-order mode and a larger count selects in-order mode. If the selected mode differs from the current one, the phase code is 1 (drain) one cycle later. Otherwise the phase stays 0.
- R3: In phase 1, `drain_req` is held until `drain_done` is seen high. The next cycle is phase 2 (spill), so drain always comes first.
- R4: In phase 2, `spill_req` is held until `spill_done` is seen high. The next cycle is phase 3 (reconfigure).
- R5: On entry to phase 3, all three unit enables take the target mode: 1 for out-of-order and 0 for in-order. They change at no other time. Phase 3 lasts exactly `RECONF_CYC` cycles and is followed by phase 4 (fill).
- R6: In phase 4, `fill_req` is held until `fill_done` is seen high, and then the phase returns to 0. `fill_rat_update` equals `fill_req` when the target is out-of-order and is 0 when the target is in-order.
- R7: A done input that arrives outside its own phase has no effect.
- R8: `fetch_stall` is 1 and `mode_valid` is 0 in every non-idle phase. In idle, `fetch_stall` is 0 and `mode_valid` is 1.
- R9: Changes in the thread count during a switch are ignored, and the switch completes to the mode chosen when it started. A mismatch that remains when the switch ends starts a new switch one cycle after the return to idle.
- R10: After a switch, `switch_cycles` holds the number of cycles spent outside idle, saturating at 2^`CNT_W`-1. The value is kept until the next switch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_threads | input | THREAD_W | Number of active threads |
| drain_req | output | 1 | Pipeline drain request |
| drain_done | input | 1 | Pipeline drained |
| spill_req | output | 1 | Register spill request |
| spill_done | input | 1 | Spill finished |
| fill_req | output | 1 | Register fill request |
| fill_done | input | 1 | Fill finished |
| fill_rat_update | output | 1 | Fill must also update rename tables |
| rename_en | output | 1 | Register renaming enable |
| ooo_sched_en | output | 1 | Out-of-order scheduler enable |
| ldq_en | output | 1 | Load queue enable |
| fetch_stall | output | 1 | Hold fetch |
| mode_valid | output | 1 | Mode settled, no switch in progress |
| phase | output | 3 | Current phase code (0 idle, 1 drain, 2 spill, 3 reconfigure, 4 fill) |
| switch_cycles | output | CNT_W | Duration of the latest switch |

## Verification
The bench builds the block with `THREAD_W`=3, `OOO_MAX`=2, `RECONF_CYC`=2 and `CNT_W`=6. With these values every thread count from 0 to 7 can be swept from both starting modes. Across the sweep, the done delays of each phase vary between zero and two cycles. The counter width of 6 means a single drain held for 70 cycles drives `switch_cycles` to its saturation value of 63.

// File: rtl/exec_mode_pkg.sv
package exec_mode_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DRAIN  = 3'd1,
    PH_SPILL  = 3'd2,
    PH_RECONF = 3'd3,
    PH_FILL   = 3'd4
  } phase_e;
endpackage

// File: rtl/mode_policy.sv
module mode_policy #(
  parameter int THREAD_W = 4,
  parameter int OOO_MAX  = 2
) (
  input  logic [THREAD_W-1:0] threads,
  output logic                want_ooo
);
  localparam logic [THREAD_W-1:0] LIMIT = OOO_MAX[THREAD_W-1:0];
  always_comb want_ooo = (threads <= LIMIT);
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import exec_mode_pkg::*;
#(
  parameter int RECONF_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   want_ooo,
  input  logic   cur_ooo,
  input  logic   drain_done,
  input  logic   spill_done,
  input  logic   fill_done,
  output phase_e phase_q,
  output logic   tgt_ooo_q,
  output logic   start,
  output logic   reconf_go
);
  localparam int RCW = (RECONF_CYC > 1) ? $clog2(RECONF_CYC) : 1;
  localparam logic [RCW-1:0] RC_LAST = RCW'(RECONF_CYC - 1);

  phase_e         phase_d;
  logic [RCW-1:0] rc_q;

  always_comb begin
    start     = (phase_q == PH_IDLE) && (want_ooo != cur_ooo);
    reconf_go = (phase_q == PH_SPILL) && spill_done;
    phase_d   = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_DRAIN;
      PH_DRAIN:  if (drain_done) phase_d = PH_SPILL;
      PH_SPILL:  if (spill_done) phase_d = PH_RECONF;
      PH_RECONF: if (rc_q == RC_LAST) phase_d = PH_FILL;
      PH_FILL:   if (fill_done) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      tgt_ooo_q <= 1'b1;
      rc_q      <= '0;
    end else begin
      phase_q <= phase_d;
      if (start) tgt_ooo_q <= want_ooo;
      if (reconf_go) rc_q <= '0;
      else if (phase_q == PH_RECONF) rc_q <= rc_q + 1'b1;
    end
  end
endmodule

// File: rtl/unit_enable.sv
module unit_enable #(
  parameter int N_UNITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               value,
  output logic [N_UNITS-1:0] en
);
  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n)    en[g] <= 1'b1;
      else if (load) en[g] <= value;
    end
  end
endmodule

// File: rtl/switch_timer.sv
module switch_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (start)                 count <= '0;
    else if (busy && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/exec_mode_ctrl.sv
module exec_mode_ctrl
  import exec_mode_pkg::*;
#(
  parameter int THREAD_W   = 4,
  parameter int OOO_MAX    = 2,
  parameter int RECONF_CYC = 4,
  parameter int CNT_W      = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [THREAD_W-1:0] active_threads,
  output logic                drain_req,
  input  logic                drain_done,
  output logic                spill_req,
  input  logic                spill_done,
  output logic                fill_req,
  input  logic                fill_done,
  output logic                fill_rat_update,
  output logic                rename_en,
  output logic                ooo_sched_en,
  output logic                ldq_en,
  output logic                fetch_stall,
  output logic                mode_valid,
  output logic [2:0]          phase,
  output logic [CNT_W-1:0]    switch_cycles
);
  localparam int N_UNITS = 3;

  logic               want_ooo, tgt_ooo, start, reconf_go;
  phase_e             ph;
  logic [N_UNITS-1:0] unit_en;

  mode_policy #(.THREAD_W(THREAD_W), .OOO_MAX(OOO_MAX)) u_policy (
    .threads (active_threads),
    .want_ooo(want_ooo)
  );

  phase_seq #(.RECONF_CYC(RECONF_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_ooo  (want_ooo),
    .cur_ooo   (unit_en[0]),
    .drain_done(drain_done),
    .spill_done(spill_done),
    .fill_done (fill_done),
    .phase_q   (ph),
    .tgt_ooo_q (tgt_ooo),
    .start     (start),
    .reconf_go (reconf_go)
  );

  unit_enable #(.N_UNITS(N_UNITS)) u_units (
    .clk  (clk),
    .rst_n(rst_n),
    .load (reconf_go),
    .value(tgt_ooo),
    .en   (unit_en)
  );

  switch_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (ph != PH_IDLE),
    .count(switch_cycles)
  );

  always_comb begin
    drain_req       = (ph == PH_DRAIN);
    spill_req       = (ph == PH_SPILL);
    fill_req        = (ph == PH_FILL);
    fill_rat_update = fill_req && tgt_ooo;
    rename_en       = unit_en[0];
    ooo_sched_en    = unit_en[1];
    ldq_en          = unit_en[2];
    fetch_stall     = (ph != PH_IDLE);
    mode_valid      = (ph == PH_IDLE);
    phase           = ph;
  end
endmodule

// File: rtl/exec_mode_ctrl_chk.sv
module exec_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drain_req,
  input logic       drain_done,
  input logic       spill_req,
  input logic       spill_done,
  input logic       fill_req,
  input logic       fill_done,
  input logic       fill_rat_update,
  input logic       rename_en,
  input logic       ooo_sched_en,
  input logic       ldq_en,
  input logic       fetch_stall,
  input logic       mode_valid,
  input logic [2:0] phase
);
  assert_reqs_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drain_req, spill_req, fill_req}));

  assert_drain_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_done |=> drain_req);

  assert_spill_after_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spill_req) |-> $past(drain_req && drain_done));

  assert_enables_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rename_en, ooo_sched_en, ldq_en}) |-> (phase == 3'd3) && $past(spill_req && spill_done));

  assert_fill_after_reconf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> $past(phase) == 3'd3);

  assert_rat_only_ooo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rat_update |-> fill_req && rename_en);

  assert_valid_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> !fetch_stall);

  assert_stall_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_stall) |-> $past(fill_req && fill_done));
endmodule

bind exec_mode_ctrl exec_mode_ctrl_chk u_chk (.*);

// File: tb/exec_mode_ctrl_tb.sv
`timescale 1ns/1ps
module exec_mode_ctrl_tb;
  localparam int TW = 3;
  localparam int OM = 2;
  localparam int RC = 2;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [TW-1:0] thr = '0;
  logic          drain_done = 0, spill_done = 0, fill_done = 0;
  logic          drain_req, spill_req, fill_req, fill_rat_update;
  logic          rename_en, ooo_sched_en, ldq_en, fetch_stall, mode_valid;
  logic [2:0]    phase;
  logic [CW-1:0] switch_cycles;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  exec_mode_ctrl #(.THREAD_W(TW), .OOO_MAX(OM), .RECONF_CYC(RC), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .active_threads(thr),
    .drain_req(drain_req), .drain_done(drain_done),
    .spill_req(spill_req), .spill_done(spill_done),
    .fill_req(fill_req), .fill_done(fill_done),
    .fill_rat_update(fill_rat_update), .rename_en(rename_en),
    .ooo_sched_en(ooo_sched_en), .ldq_en(ldq_en),
    .fetch_stall(fetch_stall), .mode_valid(mode_valid),
    .phase(phase), .switch_cycles(switch_cycles));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered at the negedge where phase 1 was first observed.
  task automatic do_switch(input int d, input int s, input int f, input bit tgt);
    int exp_cyc;
    for (int i = 0; i < d; i++) begin
      if (i == 0) begin spill_done = 1; fill_done = 1; end
      @(negedge clk);
      spill_done = 0; fill_done = 0;
      chk("R7 stray done ignored in drain", phase, 1);
      chk("R3 drain held", drain_req, 1);
      chk("R8 stall in drain", {fetch_stall, mode_valid}, 2);
    end
    drain_done = 1; @(negedge clk); drain_done = 0;
    chk("R3 spill follows drain", phase, 2);
    chk("R4 spill_req", spill_req, 1);
    for (int i = 0; i < s; i++) begin
      if (i == 0) fill_done = 1;
      @(negedge clk);
      fill_done = 0;
      chk("R4 spill held", phase, 2);
    end
    spill_done = 1; @(negedge clk); spill_done = 0;
    chk("R4 reconfigure follows spill", phase, 3);
    chk("R5 enables take target", {rename_en, ooo_sched_en, ldq_en}, tgt ? 7 : 0);
    for (int i = 1; i < RC; i++) begin
      @(negedge clk);
      chk("R5 reconfigure length", phase, 3);
    end
    @(negedge clk);
    chk("R5 fill follows reconfigure", phase, 4);
    chk("R6 fill_req", fill_req, 1);
    chk("R6 rat update", fill_rat_update, tgt);
    for (int i = 0; i < f; i++) begin
      @(negedge clk);
      chk("R6 fill held", phase, 4);
    end
    fill_done = 1; @(negedge clk); fill_done = 0;
    chk("R6 back to idle", phase, 0);
    chk("R8 released", {fetch_stall, mode_valid}, 1);
    chk("R9 mode reached", rename_en, tgt);
    exp_cyc = d + s + f + 3 + RC;
    if (exp_cyc > CMAX) exp_cyc = CMAX;
    chk("R10 switch_cycles", switch_cycles, exp_cyc);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", phase, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 phase", phase, 0);
    chk("R1 enables", {rename_en, ooo_sched_en, ldq_en}, 7);
    chk("R1 valid/stall", {mode_valid, fetch_stall}, 2);
    chk("R1 requests", {drain_req, spill_req, fill_req}, 0);
    chk("R1 switch_cycles", switch_cycles, 0);

    // Sweep from out-of-order mode
    for (int t = 0; t < (1 << TW); t++) begin
      thr = TW'(t);
      @(negedge clk);
      chk("R2 start from ooo", phase, (t > OM) ? 1 : 0);
      if (t > OM) begin
        thr = '0;  // R9: flip back mid-switch
        do_switch(t % 3, (t + 1) % 3, t % 2, 1'b0);
        @(negedge clk);
        chk("R9 restart after completion", phase, 1);
        do_switch((t + 2) % 3, t % 2, (t + 1) % 3, 1'b1);
      end
    end
    // Go in-order with a long drain (R10 saturation)
    thr = 3'd7;
    @(negedge clk);
    chk("R2 start to in-order", phase, 1);
    do_switch(70, 0, 0, 1'b0);
    // Sweep from in-order mode
    for (int t = 0; t < (1 << TW); t++) begin
      thr = TW'(t);
      @(negedge clk);
      chk("R2 start from in-order", phase, (t <= OM) ? 1 : 0);
      if (t <= OM) begin
        thr = 3'd7;
        do_switch(t % 3, t % 2, (t + 2) % 3, 1'b1);
        @(negedge clk);
        chk("R9 restart after completion", phase, 1);
        do_switch(1, (t + 1) % 3, t % 3, 1'b0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule